// File: doc/BRIEF.md
# Mains-Locked Interleaved Thyristor Firing Generator

This block drives the two gates of an anti-parallel thyristor pair from one phase-locked pulse-width waveform. Its only timing reference is a digitized pulse from a zero-crossing comparator. That pulse is high for about the negative half of the mains cycle. Because of the comparator's input network, the pulse rises a fixed time early and falls the same time late.

After reset the block stays silent while it measures two quantities from the pulse: the mains period between two rising edges, and the early-edge advance, which it derives from how much the high time exceeds half a period. Once locked, a free-running phase counter spans one mains period. Every rising edge of the pulse reloads this counter to the position where the edge is known to fall, so slow frequency drift never builds up.

One firing waveform repeats every half cycle, with the idle part first and the firing part at the end of the half. It goes to the forward gate during the positive half and to the reverse gate during the negative half. The firing width comes from a duty input, which the block samples once at the start of each half. If the pulse stops, a timeout silences both gates and raises a lost-sync flag until a new measurement completes.

Top module: `scr_fire_pwm`

## Requirements
- R1: After reset, `fwd_gate`, `rev_gate` and `lost_sync` are 0, and both gates stay 0 until the block has locked.
- R2: The block locks on the second sync rising edge after it starts hunting. The period T is the number of clocks between the two rising edges. The advance E is (high time − floor(T/2))/2, where the high time is measured from the first rise to the following fall.
- R3: At lock, and on every later sync rising edge, the phase position is loaded with floor(T/2) − E. The positive half is positions 0 to floor(T/2)−1 and the negative half is the rest, so the negative half begins E clocks after each sampled rising edge, even when the edge arrives a clock early or late.
- R4: Within each half of length H = floor(T/2), the active gate is high for exactly the last M positions, with M = floor(H × duty / 2^DUTY_W). A duty of 0 gives no pulse at all.
- R5: `fwd_gate` is high only in the positive half and `rev_gate` only in the negative half. The gate that is idle in the current half stays 0 for the whole half.
- R6: `duty_in` is sampled only on the clock edge that starts a half. A change in mid-half takes effect from the next half.
- R7: Firing starts at the first half boundary after lock. For the rest of the half in which lock occurs, both gates stay 0.
- R8: If no rising edge arrives within T + floor(T/2) clocks of the previous one, both gates go to 0 and `lost_sync` goes to 1.
- R9: After a loss, the block hunts and measures again from scratch, so a new period and advance take effect. `lost_sync` stays 1 until that lock and clears when it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Zero-crossing pulse, high around the negative half cycle, already synchronous to `clk` |
| duty_in | input | DUTY_W | Firing width as a fraction of a half cycle, in units of 2^-DUTY_W |
| fwd_gate | output | 1 | Firing command for the forward thyristor, positive half only |
| rev_gate | output | 1 | Firing command for the reverse thyristor, negative half only |
| lost_sync | output | 1 | High from a sync timeout until the next lock |

## Verification
The bench compares every clock of every half against a scoreboard entry that the driver queues at the half boundary. This shows the exact first and last firing position and that the idle gate stays quiet. A block that measured the period or the advance wrongly, or that fired from the start of the half instead of the end, shows a pulse shifted by a few positions. The bench stretches the sync period by one clock and shortens another by one: a timer that ignores the rising edge keeps a one-clock phase error, and every later pulse then starts one position early. The bench also changes the duty in mid-half and checks the full span of duty values, 0 and the maximum. A block that samples the duty live changes the pulse width inside a half, and one with a scaling error misses by a position at the maximum. The bench then removes the sync pulse to check when the timeout fires and that the gates fall silent. It relocks on a shorter mains period, which catches a block that keeps its old measurement or clears the lost flag before the new lock.

// File: rtl/scr_fire_pkg.sv
`timescale 1ns/1ps
package scr_fire_pkg;

  // Measurement / tracking states of the period meter
  typedef enum logic [1:0] {
    MS_HUNT = 2'd0,  // waiting for a first rising edge
    MS_MEAS = 2'd1,  // timing high time and full period
    MS_RUN  = 2'd2   // locked, phase tracking active
  } meas_state_e;

endpackage

// File: rtl/scr_edge_detect.sv
`timescale 1ns/1ps
module scr_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;

endmodule

// File: rtl/scr_period_meter.sv
`timescale 1ns/1ps
module scr_period_meter
  import scr_fire_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             run_o,
  output logic             lost_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] adv_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  meas_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] high_q, high_d;
  logic [CNT_W-1:0] adv_q, adv_d;
  logic             lost_q, lost_d;

  logic [CNT_W-1:0] meas_half;
  logic [CNT_W-1:0] meas_adv;
  logic [CNT_W:0]   timeout_lim;

  // Values derived from the measurement in progress
  assign meas_half   = cnt_q >> 1;
  assign meas_adv    = (high_q > meas_half) ? ((high_q - meas_half) >> 1) : '0;
  assign timeout_lim = {1'b0, period_q} + {2'b00, period_q[CNT_W-1:1]};

  // Next-state process
  always_comb begin
    state_d  = state_q;
    period_d = period_q;
    high_d   = high_q;
    adv_d    = adv_q;
    lost_d   = lost_q;
    cnt_d    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    unique case (state_q)
      MS_HUNT: begin
        if (rise_i) begin
          cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
          high_d  = '0;
          state_d = MS_MEAS;
        end
      end
      MS_MEAS: begin
        if (fall_i) high_d = cnt_q;
        if (rise_i) begin
          period_d = cnt_q;
          adv_d    = meas_adv;
          cnt_d    = {{(CNT_W-1){1'b0}}, 1'b1};
          lost_d   = 1'b0;
          state_d  = MS_RUN;
        end else if (cnt_q == CNT_MAX) begin
          state_d  = MS_HUNT;
        end
      end
      MS_RUN: begin
        if (rise_i) begin
          cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
        end else if ({1'b0, cnt_q} >= timeout_lim) begin
          lost_d  = 1'b1;
          state_d = MS_HUNT;
        end
      end
      default: state_d = MS_HUNT;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MS_HUNT;
      cnt_q    <= '0;
      period_q <= '0;
      high_q   <= '0;
      adv_q    <= '0;
      lost_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      period_q <= period_d;
      high_q   <= high_d;
      adv_q    <= adv_d;
      lost_q   <= lost_d;
    end
  end

  assign run_o      = (state_q == MS_RUN);
  assign lost_o     = lost_q;
  assign period_o   = period_q;
  assign half_o     = period_q >> 1;
  assign adv_o      = adv_q;
  assign load_o     = rise_i & ((state_q == MS_MEAS) | (state_q == MS_RUN));
  assign load_val_o = (state_q == MS_MEAS) ? (meas_half - meas_adv)
                                           : ((period_q >> 1) - adv_q);

  // R9: the lost flag only ever drops on the transition into tracking
  p_lost_clear_on_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_q) |-> (state_q == MS_RUN));

  // R8: leaving tracking for hunting always announces a loss
  p_hunt_after_run_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MS_HUNT) && ($past(state_q) == MS_RUN)) |-> lost_q);

endmodule

// File: rtl/scr_phase_timer.sv
`timescale 1ns/1ps
module scr_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             pos_half_o,
  output logic             half_start_o
);

  logic [CNT_W-1:0] ph_q, ph_d;

  // Next-state process: reload on a sync edge, else wrap at the period
  always_comb begin
    if (load_i)     ph_d = load_val_i;
    else if (run_i) ph_d = (ph_q >= period_i - 1'b1) ? '0 : ph_q + 1'b1;
    else            ph_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign pos_o        = ph_q;
  assign pos_half_o   = (ph_q < half_i);
  assign half_start_o = run_i & ~load_i & ((ph_d == '0) | (ph_d == half_i));

  // R3: while tracking, the phase never leaves the measured period
  p_phase_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (ph_q < period_i));

endmodule

// File: rtl/scr_gate_steer.sv
`timescale 1ns/1ps
module scr_gate_steer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              half_start_i,
  input  logic              pos_half_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [CNT_W-1:0]  half_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              fwd_o,
  output logic              rev_o
);

  localparam int unsigned PROD_W = CNT_W + DUTY_W;

  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              armed_q, armed_d;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  mark_len;
  logic [CNT_W-1:0]  in_half;
  logic              fire;

  // Next-state process: duty and arming change only at half boundaries
  always_comb begin
    duty_d  = half_start_i ? duty_i : duty_q;
    armed_d = run_i & (half_start_i | armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      duty_q  <= duty_d;
      armed_q <= armed_d;
    end
  end

  // Firing width scaled to the measured half period
  assign prod     = {{DUTY_W{1'b0}}, half_i} * {{CNT_W{1'b0}}, duty_q};
  assign mark_len = prod[PROD_W-1:DUTY_W];
  assign in_half  = pos_half_i ? pos_i : (pos_i - half_i);

  // Space first, mark at the end of each half
  assign fire  = run_i & armed_q & (mark_len != '0) & (in_half >= half_i - mark_len);
  assign fwd_o = fire & pos_half_i;
  assign rev_o = fire & ~pos_half_i;

  // R5: the two gates are never driven together
  p_gates_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_o && rev_o));

  // R7: the clock after lock is always silent
  p_silent_at_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (!fwd_o && !rev_o));

endmodule

// File: rtl/scr_fire_pwm.sv
`timescale 1ns/1ps
module scr_fire_pwm #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [DUTY_W-1:0] duty_in,
  output logic              fwd_gate,
  output logic              rev_gate,
  output logic              lost_sync
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_int;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  logic             rise, fall;
  logic             run, load, half_start, pos_half;
  logic [CNT_W-1:0] period, half, adv, load_val, pos;

  scr_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .sig_i  (sync_in),
    .rise_o (rise),
    .fall_o (fall)
  );

  scr_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .rise_i     (rise),
    .fall_i     (fall),
    .run_o      (run),
    .lost_o     (lost_sync),
    .period_o   (period),
    .half_o     (half),
    .adv_o      (adv),
    .load_o     (load),
    .load_val_o (load_val)
  );

  scr_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .run_i        (run),
    .load_i       (load),
    .load_val_i   (load_val),
    .period_i     (period),
    .half_i       (half),
    .pos_o        (pos),
    .pos_half_o   (pos_half),
    .half_start_o (half_start)
  );

  scr_gate_steer #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_steer (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .run_i        (run),
    .half_start_i (half_start),
    .pos_half_i   (pos_half),
    .pos_i        (pos),
    .half_i       (half),
    .duty_i       (duty_in),
    .fwd_o        (fwd_gate),
    .rev_o        (rev_gate)
  );

  // R8: a flagged loss keeps both gates quiet
  p_lost_gates_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    lost_sync |-> (!fwd_gate && !rev_gate));

  // R3: a sync edge while tracking re-phases the timer to half minus advance
  p_rephase_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rise && run) |=> (pos == $past(half) - $past(adv)));

endmodule

// File: tb/scr_fire_pwm_tb_top.sv
`timescale 1ns/1ps
module scr_fire_pwm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 16;
  localparam int DW         = 8;
  localparam int MAX_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_in = 1'b0;
  logic [DW-1:0] duty_in = '0;
  logic          fwd_gate, rev_gate, lost_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_fire_pwm #(.CNT_W(CW), .DUTY_W(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .duty_in   (duty_in),
    .fwd_gate  (fwd_gate),
    .rev_gate  (rev_gate),
    .lost_sync (lost_sync)
  );

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;
  int    bp = 0, per = 400, hlf = 200, adv = 10;
  bit    sync_en = 1'b0;
  int    rises = 0, since_rise = 0;
  bit    hold_once = 1'b0, skip_once = 1'b0;
  bit    quiet = 1'b0;
  string quiet_tag = "R1";
  string act_tag = "R4";
  int    exp_q[$];
  bit    cur_valid = 1'b0;
  int    cur_mark = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (pos %0d, t=%0t)", tag, what, act, exp, bp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Driver: one bench position per clock, pushes the expected mark per half
  task automatic tick();
    @(negedge clk);
    if (hold_once && bp == hlf - adv - 1) hold_once = 1'b0;
    else if (skip_once && bp == hlf - adv - 2) begin skip_once = 1'b0; bp = hlf - adv; end
    else bp = (bp + 1) % per;
    sync_in = sync_en && (bp >= hlf - adv || bp < adv);
    if (sync_en && bp == hlf - adv) begin rises++; since_rise = 0; end
    else since_rise++;
    if (sync_en && rises >= 2 && (bp == 0 || bp == hlf))
      exp_q.push_back((hlf * int'(duty_in)) >> DW);
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_pos(int v);
    do tick(); while (bp != v);
  endtask

  // Monitor: compares each clock against the current scoreboard entry
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (bp == 0 || bp == hlf) begin
        if (exp_q.size() > 0) begin cur_mark = exp_q.pop_front(); cur_valid = 1'b1; end
        else cur_valid = 1'b0;
      end
      if (cur_valid) begin
        if (bp < hlf) begin
          check(rev_gate == 1'b0, "R5", "idle rev_gate in positive half", int'(rev_gate), 0);
          check(int'(fwd_gate) == int'(bp >= hlf - cur_mark && cur_mark > 0), act_tag,
                "fwd_gate", int'(fwd_gate), int'(bp >= hlf - cur_mark && cur_mark > 0));
        end else begin
          check(fwd_gate == 1'b0, "R5", "idle fwd_gate in negative half", int'(fwd_gate), 0);
          check(int'(rev_gate) == int'(bp - hlf >= hlf - cur_mark && cur_mark > 0), act_tag,
                "rev_gate", int'(rev_gate), int'(bp - hlf >= hlf - cur_mark && cur_mark > 0));
        end
      end else if (quiet) begin
        check(!fwd_gate && !rev_gate, quiet_tag, "gates quiet", int'({fwd_gate, rev_gate}), 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    check(fwd_gate == 1'b0, "R1", "fwd_gate in reset", int'(fwd_gate), 0);
    check(rev_gate == 1'b0, "R1", "rev_gate in reset", int'(rev_gate), 0);
    check(lost_sync == 1'b0, "R1", "lost_sync in reset", int'(lost_sync), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Lock on a 400-clock period with 10-clock advance
    per = 400; hlf = 200; adv = 10; bp = adv - 1;
    duty_in = 8'd128; quiet = 1'b1; quiet_tag = "R1"; sync_en = 1'b1;
    while (rises < 2) tick();
    quiet_tag = "R7";                       // R7: lock half stays silent
    wait_pos(hlf);
    quiet = 1'b0;
    act_tag = "R4";
    run_ticks(2 * per);

    // R4: maximum and zero duty
    wait_pos(50); duty_in = 8'd255; run_ticks(2 * per);
    wait_pos(50); duty_in = 8'd0;   run_ticks(2 * per);

    // R6: mid-half duty changes only apply from the next half
    wait_pos(50); duty_in = 8'd64; act_tag = "R6";
    wait_pos(260); duty_in = 8'd200;
    wait_pos(120); duty_in = 8'd30;
    run_ticks(2 * per);

    // R3: one late edge and one early edge must be absorbed by re-phasing
    wait_pos(50); duty_in = 8'd8; act_tag = "R3";
    hold_once = 1'b1; run_ticks(2 * per);
    skip_once = 1'b1; run_ticks(2 * per);
    wait_pos(50); duty_in = 8'd180; run_ticks(per);

    // R8: remove sync and check timeout window
    wait_pos(adv); sync_en = 1'b0;
    while (since_rise < per + hlf - 20) tick();
    check(lost_sync == 1'b0, "R8", "lost_sync before timeout", int'(lost_sync), 0);
    while (since_rise < per + hlf + 5) tick();
    check(lost_sync == 1'b1, "R8", "lost_sync after timeout", int'(lost_sync), 1);
    check(!fwd_gate && !rev_gate, "R8", "gates after timeout", int'({fwd_gate, rev_gate}), 0);
    quiet = 1'b1; quiet_tag = "R8";
    run_ticks(2 * per);

    // R9 / R2: relock on a 300-clock period with 15-clock advance
    quiet_tag = "R9";
    per = 300; hlf = 150; adv = 15; bp = adv - 1; rises = 0;
    duty_in = 8'd100; act_tag = "R2"; sync_en = 1'b1;
    while (rises < 1) tick();
    run_ticks(20);
    check(lost_sync == 1'b1, "R9", "lost_sync held during remeasure", int'(lost_sync), 1);
    while (rises < 2) tick();
    run_ticks(3);
    check(lost_sync == 1'b0, "R9", "lost_sync after relock", int'(lost_sync), 0);
    wait_pos(hlf);
    quiet = 1'b0;
    run_ticks(3 * per);
    wait_pos(50); duty_in = 8'd255; run_ticks(2 * per);

    finish_run();
  end

endmodule